// File: doc/BRIEF.md
# RTC Interrupt Flag and Request Logic

This block holds the interrupt status and enable state of a real-time clock. Six event sources feed it as single-cycle pulses. Three of them are primary: periodic, alarm and update-ended. Three are extended: RAM-clear, wake-up alarm and kickstart. Each pulse sets a sticky flag whether or not that source is enabled. A flag ANDed with its enable contributes to one aggregate request. The aggregate appears as the top bit of the primary status register and drives an active-low interrupt pin.

Software reaches five byte-wide registers through a simple read/write strobe interface with a 3-bit select:

| Select | Register | Access |
|---|---|---|
| 0 | Primary enables | read/write |
| 1 | Primary status | read-only, cleared by reading |
| 2 | Validity | read-only |
| 3 | Extended status | write 0 to clear a flag |
| 4 | Extended enables | read/write |

Any other select code reads 0x00. Read data is combinational from the current state. The clear caused by a read takes effect at the clock edge that ends the read cycle.

The pin is driven by a two-state machine.
- ST_QUIET drives the pin high. It moves to ST_REQUEST when the aggregate request is true.
- ST_REQUEST drives the pin low. It returns to ST_QUIET when the aggregate request is false.

Top module: `rtc_irq_flags`

## Requirements
- R1: After reset, all six flags and all six enables are 0 and irq_n_o is 1.
- R2: A pulse on any event input sets its flag at the next clock edge, whatever its enable. The flag stays set until software clears it.
- R3: Primary status (select 1) reads aggregate at bit 7, periodic flag at bit 6, alarm flag at bit 5 and update-ended flag at bit 4. Bits 3..0 read 0. Writes to it are ignored.
- R4: Primary enables (select 0) store wdata bits 6 (periodic), 5 (alarm) and 4 (update-ended), and every other bit reads 0. Extended enables (select 4) store bits 2 (RAM-clear), 1 (wake-up) and 0 (kickstart), and bits 7..3 read 0.
- R5: Extended status (select 3) reads the RAM-clear flag at bit 2, the wake-up flag at bit 1 and the kickstart flag at bit 0. Bits 7..3 read 0.
- R6: The aggregate bit is 1 exactly when some flag in either group is set together with its enable.
- R7: irq_n_o goes low one clock edge after the aggregate becomes 1. It returns high one edge after the aggregate becomes 0.
- R8: A read of primary status clears the three primary flags at the end of the read cycle. The extended flags are unaffected.
- R9: Writing 0 to a flag bit of extended status clears that flag. Writing 1 leaves it unchanged.
- R10: An event pulse in the same cycle as a clear of its flag wins, and the flag ends up set.
- R11: Validity (select 2) reads vrt_i at bit 7 and 0 in bits 6..0. Writes to it are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rd_en_i | input | 1 | Read strobe, one cycle per access |
| wr_en_i | input | 1 | Write strobe |
| addr_i | input | 3 | Register select |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for the selected register |
| ev_prim_i | input | 3 | Primary event pulses: bit 2 periodic, bit 1 alarm, bit 0 update-ended |
| ev_ext_i | input | 3 | Extended event pulses: bit 2 RAM-clear, bit 1 wake-up, bit 0 kickstart |
| vrt_i | input | 1 | Valid RAM and time status |
| irq_n_o | output | 1 | Active-low interrupt request |

## Verification
The assertions assume that a read strobe and a write strobe never target the primary status register in the same cycle. They also assume that event inputs are clean one-cycle pulses sampled at the clock edge. The bench drives all inputs at the falling edge, raises at most one strobe at a time, and holds each event high for exactly one cycle. The rule that an event beats a clear is therefore only exercised where the bench deliberately places an event pulse alongside a read or a zero write.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;
    localparam int DATA_W   = 8;
    localparam int SEL_W    = 3;
    localparam int GRP_W    = 3;
    localparam int PRIM_LSB = 4;
    localparam int EXT_LSB  = 0;
    localparam int AGG_BIT  = 7;
    localparam int VRT_BIT  = 7;

    localparam logic [SEL_W-1:0] SEL_PEN  = 3'd0;
    localparam logic [SEL_W-1:0] SEL_PST  = 3'd1;
    localparam logic [SEL_W-1:0] SEL_VLD  = 3'd2;
    localparam logic [SEL_W-1:0] SEL_XST  = 3'd3;
    localparam logic [SEL_W-1:0] SEL_XEN  = 3'd4;

    typedef enum logic [0:0] {
        ST_QUIET   = 1'b0,
        ST_REQUEST = 1'b1
    } irq_state_e;
endpackage

// File: rtl/rtc_irq_flag_bank.sv
module rtc_irq_flag_bank #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] flag_o
);
    logic [W-1:0] q;

    // set dominates clear so no event is lost
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= (q & ~clr_i) | set_i;
    end

    assign flag_o = q;
endmodule

// File: rtl/rtc_irq_en_reg.sv
module rtc_irq_en_reg #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] en_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    en_o <= '0;
        else if (we_i) en_o <= d_i;
    end
endmodule

// File: rtl/rtc_irq_line_fsm.sv
module rtc_irq_line_fsm
    import rtc_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pending_i,
    output logic irq_n_o
);
    irq_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_QUIET;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_QUIET:   if (pending_i)  state_d = ST_REQUEST;
            ST_REQUEST: if (!pending_i) state_d = ST_QUIET;
            default:    state_d = ST_QUIET;
        endcase
    end

    always_comb begin
        irq_n_o = 1'b1;
        unique case (state_q)
            ST_QUIET:   irq_n_o = 1'b1;
            ST_REQUEST: irq_n_o = 1'b0;
            default:    irq_n_o = 1'b1;
        endcase
    end
endmodule

// File: rtl/rtc_irq_flags.sv
module rtc_irq_flags
    import rtc_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en_i,
    input  logic              wr_en_i,
    input  logic [SEL_W-1:0]  addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    input  logic [GRP_W-1:0]  ev_prim_i,
    input  logic [GRP_W-1:0]  ev_ext_i,
    input  logic              vrt_i,
    output logic              irq_n_o
);
    logic [GRP_W-1:0] prim_flags, ext_flags, prim_en, ext_en;
    logic [GRP_W-1:0] prim_clr, ext_clr;
    logic             pending;

    // primary flags clear on a status read; extended flags clear on zero write
    assign prim_clr = (rd_en_i && addr_i == SEL_PST) ? {GRP_W{1'b1}} : '0;
    assign ext_clr  = (wr_en_i && addr_i == SEL_XST) ? ~wdata_i[EXT_LSB +: GRP_W] : '0;

    rtc_irq_flag_bank #(.W(GRP_W)) prim_bank_i (
        .clk(clk), .rst_n(rst_n), .set_i(ev_prim_i), .clr_i(prim_clr), .flag_o(prim_flags));

    rtc_irq_flag_bank #(.W(GRP_W)) ext_bank_i (
        .clk(clk), .rst_n(rst_n), .set_i(ev_ext_i), .clr_i(ext_clr), .flag_o(ext_flags));

    rtc_irq_en_reg #(.W(GRP_W)) prim_en_i (
        .clk(clk), .rst_n(rst_n), .we_i(wr_en_i && addr_i == SEL_PEN),
        .d_i(wdata_i[PRIM_LSB +: GRP_W]), .en_o(prim_en));

    rtc_irq_en_reg #(.W(GRP_W)) ext_en_i (
        .clk(clk), .rst_n(rst_n), .we_i(wr_en_i && addr_i == SEL_XEN),
        .d_i(wdata_i[EXT_LSB +: GRP_W]), .en_o(ext_en));

    assign pending = |(prim_flags & prim_en) | |(ext_flags & ext_en);

    rtc_irq_line_fsm line_i (
        .clk(clk), .rst_n(rst_n), .pending_i(pending), .irq_n_o(irq_n_o));

    always_comb begin
        rdata_o = '0;
        case (addr_i)
            SEL_PEN: rdata_o[PRIM_LSB +: GRP_W] = prim_en;
            SEL_PST: begin
                rdata_o[PRIM_LSB +: GRP_W] = prim_flags;
                rdata_o[AGG_BIT]           = pending;
            end
            SEL_VLD: rdata_o[VRT_BIT]          = vrt_i;
            SEL_XST: rdata_o[EXT_LSB +: GRP_W] = ext_flags;
            SEL_XEN: rdata_o[EXT_LSB +: GRP_W] = ext_en;
            default: rdata_o = '0;
        endcase
    end
endmodule

// File: rtl/rtc_irq_flags_chk.sv
module rtc_irq_flags_chk
    import rtc_irq_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              rd_en_i,
    input logic [SEL_W-1:0]  addr_i,
    input logic [DATA_W-1:0] rdata_o,
    input logic [GRP_W-1:0]  ev_prim_i,
    input logic [GRP_W-1:0]  ev_ext_i,
    input logic              irq_n_o,
    input logic              pending,
    input logic [GRP_W-1:0]  prim_flags,
    input logic [GRP_W-1:0]  ext_flags
);
    AST_PRIM_EVENT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (|ev_prim_i) |=> ((prim_flags & $past(ev_prim_i)) == $past(ev_prim_i))); // R10
    AST_EXT_EVENT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (|ev_ext_i) |=> ((ext_flags & $past(ev_ext_i)) == $past(ev_ext_i))); // R2
    AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
        pending |=> !irq_n_o); // R7
    AST_IRQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        !pending |=> irq_n_o); // R7
    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && addr_i == SEL_PST && ev_prim_i == '0) |=> (prim_flags == '0)); // R8
    AST_READ_KEEPS_EXT: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && addr_i == SEL_PST) |=> ((ext_flags & $past(ext_flags)) == $past(ext_flags))); // R8
    AST_LOW_NIBBLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_i == SEL_PST) |-> (rdata_o[3:0] == 4'h0)); // R3
endmodule

bind rtc_irq_flags rtc_irq_flags_chk chk_i (
    .clk(clk), .rst_n(rst_n), .rd_en_i(rd_en_i), .addr_i(addr_i), .rdata_o(rdata_o),
    .ev_prim_i(ev_prim_i), .ev_ext_i(ev_ext_i), .irq_n_o(irq_n_o), .pending(pending),
    .prim_flags(prim_flags), .ext_flags(ext_flags));

// File: tb/rtc_irq_flags_tb_top.sv
module rtc_irq_flags_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rd_en = 1'b0, wr_en = 1'b0;
    logic [2:0] addr = 3'd0;
    logic [7:0] wdata = 8'h00, rdata;
    logic [2:0] ev_p = 3'b000, ev_x = 3'b000;
    logic       vrt = 1'b0;
    logic       irq_n;
    int         n_chk = 0, n_fail = 0;
    bit         done = 1'b0;

    always #2.5 clk = ~clk;

    rtc_irq_flags dut_i (
        .clk(clk), .rst_n(rst_n), .rd_en_i(rd_en), .wr_en_i(wr_en), .addr_i(addr),
        .wdata_i(wdata), .rdata_o(rdata), .ev_prim_i(ev_p), .ev_ext_i(ev_x),
        .vrt_i(vrt), .irq_n_o(irq_n));

    // {pen[2:0], xen[2:0], ev_prim[2:0], ev_ext[2:0], exp_status[7:0], exp_irq_n}
    localparam logic [20:0] VEC [10] = '{
        {3'b111, 3'b000, 3'b100, 3'b000, 8'hC0, 1'b0},
        {3'b000, 3'b000, 3'b111, 3'b000, 8'h70, 1'b1},
        {3'b010, 3'b000, 3'b100, 3'b000, 8'h40, 1'b1},
        {3'b010, 3'b000, 3'b010, 3'b000, 8'hA0, 1'b0},
        {3'b001, 3'b000, 3'b001, 3'b000, 8'h90, 1'b0},
        {3'b000, 3'b100, 3'b000, 3'b100, 8'h80, 1'b0},
        {3'b000, 3'b011, 3'b000, 3'b100, 8'h00, 1'b1},
        {3'b000, 3'b001, 3'b000, 3'b001, 8'h80, 1'b0},
        {3'b100, 3'b010, 3'b000, 3'b010, 8'h80, 1'b0},
        {3'b111, 3'b111, 3'b000, 3'b000, 8'h00, 1'b1}
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] v);
        @(negedge clk); addr = a; rd_en = 1'b1;
        #1 v = rdata;
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic pulse(input logic [2:0] p, input logic [2:0] x);
        @(negedge clk); ev_p = p; ev_x = x;
        @(negedge clk); ev_p = 3'b000; ev_x = 3'b000;
    endtask

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk("R1 irq_n", {7'd0, irq_n}, 8'h01);
        rd(3'd1, v); chk("R1 status", v, 8'h00);
        rd(3'd0, v); chk("R1 prim enables", v, 8'h00);
        rd(3'd3, v); chk("R1 ext status", v, 8'h00);
        rd(3'd4, v); chk("R1 ext enables", v, 8'h00);

        // table walk: R2 R3 R5 R6 R7
        for (int i = 0; i < 10; i++) begin
            wr(3'd0, {1'b0, VEC[i][20:18], 4'h0});
            wr(3'd4, {5'd0, VEC[i][17:15]});
            pulse(VEC[i][14:12], VEC[i][11:9]);
            @(negedge clk); #1;
            chk("R7 irq_n vector", {7'd0, irq_n}, {7'd0, VEC[i][0]});
            rd(3'd1, v); chk("R6 status vector", v, VEC[i][8:1]);
            rd(3'd3, v); chk("R5 ext status vector", v, {5'd0, VEC[i][11:9]});
            wr(3'd3, 8'h00);
            @(negedge clk); #1;
            chk("R7 irq released", {7'd0, irq_n}, 8'h01);
        end

        // R4 enable register readback
        wr(3'd0, 8'hFF); rd(3'd0, v); chk("R4 prim enables", v, 8'h70);
        wr(3'd4, 8'hFF); rd(3'd4, v); chk("R4 ext enables", v, 8'h07);
        wr(3'd0, 8'h00); wr(3'd4, 8'h00);

        // R8 read clears primary, keeps extended
        pulse(3'b101, 3'b011);
        rd(3'd1, v); chk("R8 first read", v, 8'h50);
        rd(3'd1, v); chk("R8 second read", v, 8'h00);
        rd(3'd3, v); chk("R8 ext kept", v, 8'h03);

        // R9 write 1 keeps, write 0 clears
        wr(3'd3, 8'hFF); rd(3'd3, v); chk("R9 write ones", v, 8'h03);
        wr(3'd3, 8'h01); rd(3'd3, v); chk("R9 clear wake", v, 8'h01);
        wr(3'd3, 8'h00); rd(3'd3, v); chk("R9 clear all", v, 8'h00);

        // R3 writes to status ignored
        pulse(3'b010, 3'b000);
        wr(3'd1, 8'h00); rd(3'd1, v); chk("R3 write ignored", v, 8'h20);

        // R10 event beats read clear
        @(negedge clk); addr = 3'd1; rd_en = 1'b1; ev_p = 3'b100;
        #1 v = rdata; chk("R10 read during event", v, 8'h00);
        @(negedge clk); rd_en = 1'b0; ev_p = 3'b000;
        rd(3'd1, v); chk("R10 primary survives", v, 8'h40);
        // R10 event beats zero write
        @(negedge clk); addr = 3'd3; wdata = 8'h00; wr_en = 1'b1; ev_x = 3'b001;
        @(negedge clk); wr_en = 1'b0; ev_x = 3'b000;
        rd(3'd3, v); chk("R10 ext survives", v, 8'h01);
        wr(3'd3, 8'h00);

        // R11 validity register
        wr(3'd2, 8'hFF); rd(3'd2, v); chk("R11 vrt low", v, 8'h00);
        vrt = 1'b1; rd(3'd2, v); chk("R11 vrt high", v, 8'h80);
        rd(3'd7, v); chk("R11 unused select", v, 8'h00);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(5.0 * 100000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule